// File: doc/BRIEF.md
# Extended Integer Divide Unit

A sequential radix-2 divider for a 16-bit microcontroller datapath. The caller reads the accumulator D and the index registers X and Y, presents them together with an operation code, and pulses `start`. The unit runs a shift-and-subtract loop on operand magnitudes for 32 cycles. It then applies the signs in one correction cycle. It returns a quotient, a remainder, the four condition flags C, Z, N and V, and the register codes the caller should write the two results into.

Three operations are supported:

- A signed 16/16 divide of D by X.
- An unsigned 32/16 divide of the pair Y:D by X, with Y holding the upper half.
- A signed 32/16 divide of Y:D by X.

A zero divisor raises C, withholds the write enable and leaves every other result output untouched. Only one operation is in flight at a time.

Top module: `ediv_unit`

## Requirements
- R1: Operation code 0 is signed 16/16. The dividend is D and the divisor is X, both in two's complement. The quotient truncates toward zero, and the remainder carries the sign of the dividend. `quot_dst` reports 1 (X) and `rem_dst` reports 0 (D).
- R2: Operation codes 1 and 3 are unsigned 32/16. The dividend is {Y, D} and the divisor is X. `quot_dst` reports 2 (Y) and `rem_dst` reports 0 (D).
- R3: Operation code 2 is signed 32/16. The dividend is {Y, D} and the divisor is X, both in two's complement. It uses the truncation and remainder sign rules of R1. `quot_dst` reports 2 (Y) and `rem_dst` reports 0 (D).
- R4: A zero divisor gives `flag_c`=1 and `wr_en`=0. In that case `quot`, `rem`, `flag_z`, `flag_n` and `flag_v` keep the values they had before the operation.
- R5: Every division with a nonzero divisor gives `flag_c`=0 and `wr_en`=1.
- R6: On success, `flag_z` is 1 exactly when the full quotient is zero. `flag_n` equals bit 15 of the delivered quotient.
- R7: For the unsigned operation, `flag_v` is 1 exactly when the quotient exceeds 65535.
- R8: For both signed operations, `flag_v` is 1 exactly when the quotient lies outside -32768..32767. On overflow, `quot` still carries the low 16 bits of the true quotient.
- R9: Suppose `start` is sampled high at clock edge k while `busy` is low. Then `busy` is high after edges k through k+32. After edge k+33, `done` is high for exactly one cycle and `busy` is low.
- R10: `start` is ignored while `busy` is high, and operand changes during that time do not alter the result. A `start` in the cycle where `done` is high begins a new operation.
- R11: After reset, `busy`, `done`, `wr_en`, all flags, `quot` and `rem` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; taken when busy is low |
| op | input | 2 | 0 signed 16/16, 1 or 3 unsigned 32/16, 2 signed 32/16 |
| d_in | input | 16 | Value of register D |
| x_in | input | 16 | Value of register X (divisor) |
| y_in | input | 16 | Value of register Y (upper dividend half) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 16 | Quotient result |
| rem | output | 16 | Remainder result |
| quot_dst | output | 2 | Register code for the quotient (0 D, 1 X, 2 Y) |
| rem_dst | output | 2 | Register code for the remainder |
| wr_en | output | 1 | Results should be written back |
| flag_c | output | 1 | Divide-by-zero flag |
| flag_z | output | 1 | Zero quotient flag |
| flag_n | output | 1 | Negative quotient flag |
| flag_v | output | 1 | Quotient overflow flag |

## Verification
Two functions can fall in the same cycle: completing one operation with its `done` pulse, and accepting the next `start`. The bench raises `start` with fresh operands in exactly the cycle it first sees `done`. It first judges the old result held on the outputs in that cycle. It then checks that the new operation completes after the full latency with its own values. Separately, a `start` with different operands is injected mid-run. The running result must come out unchanged, on the original schedule.

// File: rtl/ediv_pkg.sv
package ediv_pkg;

    typedef enum logic [1:0] {
        OP_SDIV16  = 2'd0,
        OP_UDIV32  = 2'd1,
        OP_SDIV32  = 2'd2,
        OP_UDIV32B = 2'd3
    } div_op_e;

    typedef enum logic [1:0] {
        RC_D    = 2'd0,
        RC_X    = 2'd1,
        RC_Y    = 2'd2,
        RC_NONE = 2'd3
    } reg_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic is_signed;
        logic wide;
        logic neg_dvd;
        logic neg_dvs;
        logic dvs_zero;
    } div_mode_t;

    function automatic logic op_is_signed(input logic [1:0] op);
        return (op == OP_SDIV16) || (op == OP_SDIV32);
    endfunction

    function automatic logic op_is_wide(input logic [1:0] op);
        return op != OP_SDIV16;
    endfunction

endpackage

// File: rtl/ediv_prep.sv
module ediv_prep import ediv_pkg::*; #(
    parameter int W = 16
) (
    input  logic [1:0]     op,
    input  logic [W-1:0]   d_in,
    input  logic [W-1:0]   x_in,
    input  logic [W-1:0]   y_in,
    output div_mode_t      mode,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvs_mag
);
    logic [2*W-1:0] dvd_raw;

    always_comb begin
        mode.is_signed = op_is_signed(op);
        mode.wide      = op_is_wide(op);
        dvd_raw        = mode.wide ? {y_in, d_in} : {{W{d_in[W-1]}}, d_in};
        mode.neg_dvd   = mode.is_signed & dvd_raw[2*W-1];
        mode.neg_dvs   = mode.is_signed & x_in[W-1];
        mode.dvs_zero  = (x_in == '0);
        dvd_mag        = mode.neg_dvd ? -dvd_raw : dvd_raw;
        dvs_mag        = mode.neg_dvs ? -x_in : x_in;
    end
endmodule

// File: rtl/ediv_core.sv
module ediv_core import ediv_pkg::*; #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dvs_mag,
    output logic           busy,
    output logic           in_fix,
    output logic [2*W-1:0] quo_mag,
    output logic [W-1:0]   rem_mag
);
    localparam int STEPS = 2 * W;
    localparam int CW    = $clog2(STEPS);

    seq_state_e     state;
    logic [CW-1:0]  cnt;
    logic [W-1:0]   acc;
    logic [2*W-1:0] shreg;
    logic [W-1:0]   dvs;

    logic [W:0]     trial;
    logic [W:0]     diff;
    logic           fits;

    always_comb begin
        trial = {acc, shreg[2*W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = ~diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            acc   <= '0;
            shreg <= '0;
            dvs   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                        acc   <= '0;
                        shreg <= dvd_mag;
                        dvs   <= dvs_mag;
                    end
                end
                ST_RUN: begin
                    acc   <= fits ? diff[W-1:0] : trial[W-1:0];
                    shreg <= {shreg[2*W-2:0], fits};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(STEPS - 1)) state <= ST_FIX;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign in_fix  = (state == ST_FIX);
    assign quo_mag = shreg;
    assign rem_mag = acc;
endmodule

// File: rtl/ediv_post.sv
module ediv_post import ediv_pkg::*; #(
    parameter int W = 16
) (
    input  div_mode_t      mode,
    input  logic [2*W-1:0] quo_mag,
    input  logic [W-1:0]   rem_mag,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem,
    output logic           z,
    output logic           n,
    output logic           v
);
    logic           neg_q;
    logic [W-1:0]   q_lo;
    logic [2*W-1:0] lim;

    always_comb begin
        neg_q = mode.neg_dvd ^ mode.neg_dvs;
        q_lo  = quo_mag[W-1:0];
        quo   = neg_q ? -q_lo : q_lo;
        rem   = mode.neg_dvd ? -rem_mag : rem_mag;
        z     = (quo_mag == '0);
        n     = quo[W-1];
        lim   = (2*W)'(1) << (W - 1);
        if (!neg_q) lim = lim - (2*W)'(1);
        if (mode.is_signed) v = (quo_mag > lim);
        else                v = |quo_mag[2*W-1:W];
    end
endmodule

// File: rtl/ediv_unit.sv
module ediv_unit import ediv_pkg::*; #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic [1:0]   quot_dst,
    output logic [1:0]   rem_dst,
    output logic         wr_en,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_v
);
    div_mode_t      mode_now;
    div_mode_t      mode_q;
    logic [2*W-1:0] dvd_mag;
    logic [W-1:0]   dvs_mag;
    logic [2*W-1:0] quo_mag;
    logic [W-1:0]   rem_mag;
    logic           in_fix;
    logic           load;
    logic [W-1:0]   quo_s;
    logic [W-1:0]   rem_s;
    logic           z_s, n_s, v_s;

    assign load = start & ~busy;

    ediv_prep #(.W(W)) u_prep (
        .op(op), .d_in(d_in), .x_in(x_in), .y_in(y_in),
        .mode(mode_now), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag)
    );

    ediv_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .load(load),
        .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
        .busy(busy), .in_fix(in_fix),
        .quo_mag(quo_mag), .rem_mag(rem_mag)
    );

    ediv_post #(.W(W)) u_post (
        .mode(mode_q), .quo_mag(quo_mag), .rem_mag(rem_mag),
        .quo(quo_s), .rem(rem_s), .z(z_s), .n(n_s), .v(v_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            done     <= 1'b0;
            quot     <= '0;
            rem      <= '0;
            quot_dst <= RC_NONE;
            rem_dst  <= RC_D;
            wr_en    <= 1'b0;
            flag_c   <= 1'b0;
            flag_z   <= 1'b0;
            flag_n   <= 1'b0;
            flag_v   <= 1'b0;
        end else begin
            if (load) mode_q <= mode_now;
            done <= in_fix;
            if (in_fix) begin
                quot_dst <= mode_q.wide ? RC_Y : RC_X;
                rem_dst  <= RC_D;
                flag_c   <= mode_q.dvs_zero;
                wr_en    <= ~mode_q.dvs_zero;
                if (!mode_q.dvs_zero) begin
                    quot   <= quo_s;
                    rem    <= rem_s;
                    flag_z <= z_s;
                    flag_n <= n_s;
                    flag_v <= v_s;
                end
            end
        end
    end
endmodule

// File: rtl/ediv_unit_chk.sv
module ediv_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quot,
    input logic [W-1:0] rem,
    input logic [1:0]   quot_dst,
    input logic [1:0]   rem_dst,
    input logic         wr_en,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_v
);
    localparam int LAT = 2 * W + 2;
    localparam int LW  = $clog2(LAT + 2) + 1;

    logic [LW-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= LW'(1);
        else if (busy)           lat_cnt <= lat_cnt + 1'b1;
    end

    // R11
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done && !wr_en && !flag_c));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (lat_cnt == LW'(LAT)));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));

    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_c) |-> (!wr_en && $stable(quot) && $stable(rem)
                              && $stable(flag_z) && $stable(flag_n) && $stable(flag_v)));

    // R5
    success_wr_chk: assert property (@(posedge clk) disable iff (rst) (done && !flag_c) |-> wr_en);

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !flag_c && !flag_v) |-> (flag_z == (quot == '0)));

    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !flag_c) |-> (flag_n == quot[W-1]));

    // R1
    dst_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem_dst == 2'd0 && (quot_dst == 2'd1 || quot_dst == 2'd2)));
endmodule

bind ediv_unit ediv_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .quot(quot), .rem(rem), .quot_dst(quot_dst), .rem_dst(rem_dst),
    .wr_en(wr_en), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v)
);

// File: tb/ediv_unit_bench.sv
module ediv_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 33;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [15:0] d_in = '0, x_in = '0, y_in = '0;
    logic        busy, done, wr_en, flag_c, flag_z, flag_n, flag_v;
    logic [15:0] quot, rem;
    logic [1:0]  quot_dst, rem_dst;

    int checks = 0;
    int errs   = 0;

    logic [15:0] e_quot = '0, e_rem = '0;
    logic        e_z = 1'b0, e_n = 1'b0, e_v = 1'b0, e_c = 1'b0, e_wr = 1'b0;
    logic [1:0]  e_qdst = 2'd0;
    logic [1:0]  cur_op = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ediv_unit u_ediv_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .d_in(d_in), .x_in(x_in), .y_in(y_in),
        .busy(busy), .done(done), .quot(quot), .rem(rem),
        .quot_dst(quot_dst), .rem_dst(rem_dst), .wr_en(wr_en),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model computed from the requirements with 64-bit arithmetic.
    task automatic model(input logic [1:0] o, input logic [15:0] d, input logic [15:0] x,
                         input logic [15:0] y);
        longint a, b, q, r;
        cur_op = o;
        e_qdst = (o == 2'd0) ? 2'd1 : 2'd2;
        if (x == 16'd0) begin
            e_c  = 1'b1;
            e_wr = 1'b0;
        end else begin
            case (o)
                2'd0: begin a = longint'($signed(d)); b = longint'($signed(x)); end
                2'd2: begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
                default: begin a = {32'd0, y, d}; b = {48'd0, x}; end
            endcase
            q = a / b;
            r = a % b;
            e_quot = q[15:0];
            e_rem  = r[15:0];
            e_z    = (q == 0);
            e_n    = q[15];
            if (o == 2'd1 || o == 2'd3) e_v = (q > 65535);
            else                        e_v = (q > 32767) || (q < -32768);
            e_c  = 1'b0;
            e_wr = 1'b1;
        end
    endtask

    function automatic string qtag(input logic [1:0] o);
        if (o == 2'd0) return "R1";
        if (o == 2'd2) return "R3";
        return "R2";
    endfunction

    // Caller stands at a negedge; the following posedge takes the request.
    task automatic issue(input logic [1:0] o, input logic [15:0] d, input logic [15:0] x,
                         input logic [15:0] y);
        op = o; d_in = d; x_in = x; y_in = y; start = 1'b1;
        model(o, d, x, y);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input bit inject);
        int n = 0;
        while (!done && n < LATENCY + 5) begin
            if (!busy) chk("R9 busy during run", {31'd0, busy}, 32'd1);
            if (inject && n == 5) begin
                start = 1'b1; op = 2'd2;
                d_in = $urandom; x_in = $urandom; y_in = $urandom;
            end
            @(posedge clk);
            @(negedge clk);
            if (inject && n == 5) start = 1'b0;
            n++;
        end
        chk("R9 latency", n, LATENCY);
        chk("R9 busy low at done", {31'd0, busy}, 32'd0);
    endtask

    task automatic check_result(input string ctx);
        string t;
        t = (e_c) ? "R4" : qtag(cur_op);
        chk({t, " quot ", ctx}, {16'd0, quot}, {16'd0, e_quot});
        chk({t, " rem ", ctx}, {16'd0, rem}, {16'd0, e_rem});
        chk({qtag(cur_op), " quot_dst ", ctx}, {30'd0, quot_dst}, {30'd0, e_qdst});
        chk({qtag(cur_op), " rem_dst ", ctx}, {30'd0, rem_dst}, 32'd0);
        chk({e_c ? "R4" : "R5", " flag_c ", ctx}, {31'd0, flag_c}, {31'd0, e_c});
        chk({e_c ? "R4" : "R5", " wr_en ", ctx}, {31'd0, wr_en}, {31'd0, e_wr});
        chk({e_c ? "R4" : "R6", " flag_z ", ctx}, {31'd0, flag_z}, {31'd0, e_z});
        chk({e_c ? "R4" : "R6", " flag_n ", ctx}, {31'd0, flag_n}, {31'd0, e_n});
        chk({e_c ? "R4" : ((cur_op == 2'd1 || cur_op == 2'd3) ? "R7" : "R8"), " flag_v ", ctx},
            {31'd0, flag_v}, {31'd0, e_v});
    endtask

    task automatic run(input logic [1:0] o, input logic [15:0] d, input logic [15:0] x,
                       input logic [15:0] y, input string ctx);
        issue(o, d, x, y);
        wait_done(1'b0);
        check_result(ctx);
        @(posedge clk);
        @(negedge clk);
        chk("R9 done single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 wr_en", {31'd0, wr_en}, 32'd0);
        chk("R11 flags", {28'd0, flag_c, flag_z, flag_n, flag_v}, 32'd0);
        chk("R11 quot/rem", {quot, rem}, 32'd0);

        // Directed corner cases
        run(2'd0, 16'd7, 16'hFFFE, 16'd0, "7/-2");
        run(2'd0, 16'hFFF9, 16'd2, 16'd0, "-7/2");
        run(2'd0, 16'h8000, 16'hFFFF, 16'd0, "min/-1 R8");
        run(2'd0, 16'd3, 16'd5, 16'd0, "zero quotient");
        run(2'd1, 16'h0000, 16'd1, 16'h0001, "R7 0x10000/1");
        run(2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFE, "R7 max fit");
        run(2'd3, 16'h1234, 16'd16, 16'h0005, "op3 alias");
        run(2'd2, 16'h0000, 16'hFFFF, 16'h8000, "R8 min32/-1");
        run(2'd2, 16'h8000, 16'hFFFF, 16'hFFFF, "R8 edge -32768");
        run(2'd2, 16'hFFF9, 16'd2, 16'hFFFF, "-7/2 wide");
        run(2'd1, 16'd100, 16'd7, 16'd0, "before zero");
        run(2'd2, 16'h5555, 16'd0, 16'h1111, "R4 zero divisor");
        run(2'd0, 16'h1234, 16'd0, 16'd0, "R4 zero divisor 16");

        // R10: start during busy is ignored
        issue(2'd0, 16'd1000, 16'd7, 16'd0);
        wait_done(1'b1);
        check_result("R10 ignore start");

        // R10: start in the done cycle begins a new operation
        issue(2'd1, 16'h4321, 16'd9, 16'h0002);
        wait_done(1'b0);
        check_result("R10 first of pair");
        issue(2'd2, 16'hABCD, 16'hFF00, 16'hFFFF);
        wait_done(1'b0);
        check_result("R10 back-to-back");

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            logic [1:0]  ro;
            logic [15:0] rd, rx, ry;
            int sel;
            ro  = 2'($urandom % 4);
            rd  = 16'($urandom);
            ry  = 16'($urandom);
            sel = int'($urandom % 8);
            if (sel == 0)      rx = 16'd0;
            else if (sel < 3)  rx = 16'($urandom % 8);
            else               rx = 16'($urandom);
            if ($urandom % 2 == 1) ry = {16{rd[15]}};
            run(ro, rd, rx, ry, "random");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule